// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Sample Voting

This block receives asynchronous serial characters on a single line. A clock enable that pulses at sixteen times the bit rate paces all sampling. While no character is in progress, every tick looks at the line, and the first low sample is taken as the possible leading edge of a start bit. That tick counts as sample 1. Samples 8, 9 and 10 of the start bit are then put to a two-of-three vote. A high result throws the edge away as a spike, and a low result commits the receiver to a character.

Each later bit lasts exactly sixteen ticks, counted on from sample 1 of the start bit. Its value is the majority of its own samples 8, 9 and 10. Data arrives least significant bit first: eight data bits, or nine when the wide mode is selected. A stop bit follows and is voted in the same way. The character is then placed in an output holding stage with a completion flag, a framing-error flag and an overrun flag. The consumer pulses a read strobe to release it.

The serial line passes through a two-stage synchronizer, so a tick samples the line as it stood two clocks earlier. Reset is asserted asynchronously and released on the clock.

Top module: `uart_rx_vote`

## Requirements
- R1: While idle and enabled, a tick that samples the line low starts a character, and that tick is sample 1 of the start bit. A tick that samples it high leaves the receiver idle.
- R2: If at least two of start-bit samples 8, 9 and 10 are high, the start is dropped with no character delivered, and the receiver resumes the edge search. A low pulse of 8 ticks or fewer is rejected. A low pulse of 9 ticks is accepted.
- R3: Each data bit is the majority of samples 8, 9 and 10 of its own 16-tick period, and bits are taken least significant first. A single disturbed sample among the three does not change the result. Two disturbed samples invert it.
- R4: With mode9 low, 8 data bits are received. They appear on rx_data[7:0] (bit 0 first on the line), and rx_bit8 reads 0.
- R5: With mode9 high, 9 data bits are received. The first eight appear on rx_data and the ninth on rx_bit8.
- R6: The stop bit is voted like a data bit. A low result delivers the character with frame_err = 1, and a high result gives frame_err = 0.
- R7: rx_done goes to 1 when a character is loaded into the output, and a rd_strobe pulse clears it.
- R8: If a character completes while rx_done is 1 and no read occurs in that cycle, overrun goes to 1 and rx_data, rx_bit8 and frame_err keep the older character. overrun returns to 0 when the next character is loaded.
- R9: On the tick right after the stop-bit decision (stop sample 11), the receiver can detect a new start edge.
- R10: While rx_en is low, the receiver stays idle, ignores the line and abandons any partial character.
- R11: After reset, rx_done, frame_err, overrun, rx_bit8 and rx_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| mode9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rd_strobe | input | 1 | Read pulse that releases the held character |
| rxd | input | 1 | Serial input line, idle high |
| rx_data | output | 8 | Low 8 data bits of the held character |
| rx_bit8 | output | 1 | Ninth data bit (0 in 8-bit mode) |
| rx_done | output | 1 | A received character is waiting |
| frame_err | output | 1 | The held character had a low stop bit |
| overrun | output | 1 | A character was lost because the previous one was unread |

## Verification
The bench uses the default parameters: 16 ticks per bit, voting from sample 8, and 8 data bits. Ticks come every three clocks. At that size every 8-bit value can be swept, along with every single-sample disturbance on every bit position of a character. Spike lengths are stepped through the whole reject/accept boundary. A spread of 9-bit values, the framing, overrun, back-to-back and disable sequences also fit in the cycle budget.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_a,
  input  logic cap_b,
  input  logic line,
  output logic maj
);
  logic sa_q, sb_q, sa_d, sb_d;

  always_comb begin
    sa_d = cap_a ? line : sa_q;
    sb_d = cap_b ? line : sb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= 1'b1;
      sb_q <= 1'b1;
    end else begin
      sa_q <= sa_d;
      sb_q <= sb_d;
    end
  end

  // the third sample is the live line value on the deciding tick
  assign maj = (sa_q & sb_q) | (sa_q & line) | (sb_q & line);
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int SMP_A  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              mode9,
  input  logic              line,
  input  logic              maj,
  output logic              cap_a,
  output logic              cap_b,
  output logic              char_done,
  output logic              stop_bit,
  output logic [DATA_W-1:0] char_data,
  output logic              char_b8,
  output rx_state_e         state
);
  localparam int CNT_W = $clog2(OVS) + 1;
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam int SH_W  = DATA_W + 1;
  localparam logic [CNT_W-1:0] IDX_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] IDX_A    = CNT_W'(SMP_A);
  localparam logic [CNT_W-1:0] IDX_B    = CNT_W'(SMP_A + 1);
  localparam logic [CNT_W-1:0] IDX_C    = CNT_W'(SMP_A + 2);
  localparam logic [BIT_W-1:0] BITS_N   = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] BITS_W9  = BIT_W'(DATA_W + 1);

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d, idx_nx;
  logic [BIT_W-1:0] bit_q, bit_d, nbits;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic             m9_q, m9_d;
  logic             busy, step;

  always_comb begin
    busy   = (st_q != RX_IDLE);
    step   = tick & en & busy;
    idx_nx = (idx_q == IDX_LAST) ? IDX_ONE : idx_q + IDX_ONE;
    nbits  = m9_q ? BITS_W9 : BITS_N;
    cap_a  = step & (idx_nx == IDX_A);
    cap_b  = step & (idx_nx == IDX_B);
  end

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    m9_d      = m9_q;
    char_done = 1'b0;
    stop_bit  = 1'b1;
    if (!en) begin
      st_d = RX_IDLE;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_d  = RX_START;
            idx_d = IDX_ONE;
            m9_d  = mode9;
          end
        end
        RX_START: begin
          idx_d = idx_nx;
          if (idx_nx == IDX_C) begin
            if (maj) begin
              st_d = RX_IDLE;
            end else begin
              st_d  = RX_DATA;
              bit_d = '0;
            end
          end
        end
        RX_DATA: begin
          idx_d = idx_nx;
          if (idx_nx == IDX_C) begin
            sh_d  = {maj, sh_q[SH_W-1:1]};
            bit_d = bit_q + BIT_W'(1);
            if (bit_q + BIT_W'(1) == nbits) st_d = RX_STOP;
          end
        end
        RX_STOP: begin
          idx_d = idx_nx;
          if (idx_nx == IDX_C) begin
            char_done = 1'b1;
            stop_bit  = maj;
            st_d      = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      idx_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      m9_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      m9_q  <= m9_d;
    end
  end

  always_comb begin
    if (m9_q) begin
      char_data = sh_q[DATA_W-1:0];
      char_b8   = sh_q[SH_W-1];
    end else begin
      char_data = sh_q[SH_W-1:1];
      char_b8   = 1'b0;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic              stop_bit,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_b8,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              b8,
  output logic              full,
  output logic              ferr,
  output logic              ovr
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              b8_q, b8_d, full_q, full_d, ferr_q, ferr_d, ovr_q, ovr_d;

  always_comb begin
    data_d = data_q;
    b8_d   = b8_q;
    full_d = full_q;
    ferr_d = ferr_q;
    ovr_d  = ovr_q;
    if (char_done && (!full_q || rd)) begin
      data_d = char_data;
      b8_d   = char_b8;
      ferr_d = ~stop_bit;
      ovr_d  = 1'b0;
      full_d = 1'b1;
    end else if (char_done) begin
      ovr_d = 1'b1;
    end else if (rd) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      b8_q   <= 1'b0;
      full_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      b8_q   <= b8_d;
      full_q <= full_d;
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
    end
  end

  assign data = data_q;
  assign b8   = b8_q;
  assign full = full_q;
  assign ferr = ferr_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int SMP_A  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_en,
  input  logic              mode9,
  input  logic              rd_strobe,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_done,
  output logic              frame_err,
  output logic              overrun
);
  logic [1:0]        rst_sq;
  logic              rst_int_n;
  logic              line_s, maj, cap_a, cap_b, char_done, stop_bit, char_b8;
  logic [DATA_W-1:0] char_data;
  rx_state_e         st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  rx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(rxd), .dout(line_s)
  );

  rx_vote u_vote (
    .clk(clk), .rst_n(rst_int_n), .cap_a(cap_a), .cap_b(cap_b),
    .line(line_s), .maj(maj)
  );

  rx_ctrl #(.OVS(OVS), .SMP_A(SMP_A), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .tick(baud_tick), .en(rx_en),
    .mode9(mode9), .line(line_s), .maj(maj), .cap_a(cap_a), .cap_b(cap_b),
    .char_done(char_done), .stop_bit(stop_bit), .char_data(char_data),
    .char_b8(char_b8), .state(st)
  );

  rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .char_done(char_done), .stop_bit(stop_bit),
    .char_data(char_data), .char_b8(char_b8), .rd(rd_strobe),
    .data(rx_data), .b8(rx_bit8), .full(rx_done), .ferr(frame_err),
    .ovr(overrun)
  );
endmodule

// File: rtl/uart_rx_vote_chk.sv
module uart_rx_vote_chk
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              baud_tick,
  input logic              rx_en,
  input logic              rd_strobe,
  input logic              line_s,
  input logic              char_done,
  input rx_state_e         st,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit8,
  input logic              rx_done,
  input logic              frame_err,
  input logic              overrun
);
  // R1: a high sample while idle keeps the search going
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && rx_en && baud_tick && line_s) |=> (st == RX_IDLE));

  // R7: a read with no new character arriving empties the holding stage
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done) |=> !rx_done);

  // R8: overrun only rises while a character was already waiting
  p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_done));

  // R8: unread data is never replaced
  p_keep_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rd_strobe) |=> ($stable(rx_data) && $stable(rx_bit8) && $stable(frame_err)));

  // R10: disable forces the idle search
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == RX_IDLE));

  // R7: completion only follows a delivered character
  p_done_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(char_done));
endmodule

bind uart_rx_vote uart_rx_vote_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
  .rd_strobe(rd_strobe), .line_s(line_s), .char_done(char_done), .st(st),
  .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_done(rx_done),
  .frame_err(frame_err), .overrun(overrun)
);

// File: tb/sim_uart_rx_vote.sv
module sim_uart_rx_vote;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_en = 1'b0;
  logic       mode9 = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_done, frame_err, overrun;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  ended   = 1'b0;

  always #4 clk = ~clk;

  uart_rx_vote u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
    .mode9(mode9), .rd_strobe(rd_strobe), .rxd(rxd), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .rx_done(rx_done), .frame_err(frame_err),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line value is set three clocks ahead of the tick that samples it
  task automatic step_tick(input logic v);
    rxd = v;
    @(negedge clk);
    @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input logic [2:0] mask);
    for (int s = 1; s <= 16; s++) begin
      if (s >= 8 && s <= 10) step_tick(v ^ mask[s-8]);
      else                   step_tick(v);
    end
  endtask

  // fbit: 0 = start, 1..n = data, n+1 = stop; fmask flips samples 8/9/10
  task automatic send_char(input logic [8:0] val, input bit nine, input logic stopv,
                           input int stop_len, input int fbit, input logic [2:0] fmask);
    int nb;
    nb = nine ? 9 : 8;
    send_bit(1'b0, (fbit == 0) ? fmask : 3'b000);
    for (int i = 0; i < nb; i++)
      send_bit(val[i], (fbit == i + 1) ? fmask : 3'b000);
    for (int s = 1; s <= stop_len; s++) begin
      logic v;
      v = (s <= 10) ? stopv : 1'b1;
      if (fbit == nb + 1 && s >= 8 && s <= 10) v = v ^ fmask[s-8];
      step_tick(v);
    end
  endtask

  task automatic pulse_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) step_tick(1'b1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(rx_done == 1'b0 && frame_err == 1'b0 && overrun == 1'b0, "R11 flags",
        {rx_done, frame_err, overrun}, 0);
    chk(rx_data == 8'h00 && rx_bit8 == 1'b0, "R11 data", {rx_bit8, rx_data}, 0);
    rx_en = 1'b1;
    idle_ticks(4);

    // R3 R4 R7: every 8-bit value, LSB first
    for (int v = 0; v < 256; v++) begin
      send_char(9'(v), 1'b0, 1'b1, 16, -1, 3'b000);
      chk(rx_done == 1'b1, "R7 done set", rx_done, 1);
      chk(rx_data == 8'(v) && rx_bit8 == 1'b0, "R3/R4 data", {rx_bit8, rx_data}, v);
      chk(frame_err == 1'b0 && overrun == 1'b0, "R6 clean stop", {frame_err, overrun}, 0);
      pulse_read();
      chk(rx_done == 1'b0, "R7 read clears", rx_done, 0);
    end

    // R5: nine-bit mode
    mode9 = 1'b1;
    for (int i = 0; i < 32; i++) begin
      logic [8:0] v;
      v = 9'((i * 37 + 5) & 511);
      send_char(v, 1'b1, 1'b1, 16, -1, 3'b000);
      chk(rx_done == 1'b1 && rx_data == v[7:0] && rx_bit8 == v[8], "R5 nine-bit",
          {rx_bit8, rx_data}, v);
      pulse_read();
    end
    mode9 = 1'b0;

    // R3: one disturbed sample on any bit does not change the character
    for (int fb = 0; fb <= 9; fb++) begin
      for (int m = 0; m < 3; m++) begin
        send_char(9'h0A5, 1'b0, 1'b1, 16, fb, 3'(1 << m));
        chk(rx_done == 1'b1 && rx_data == 8'hA5 && frame_err == 1'b0, "R3 single flip",
            {frame_err, rx_data}, 8'hA5);
        pulse_read();
      end
    end

    // R3: two disturbed samples invert the bit
    send_char(9'h000, 1'b0, 1'b1, 16, 1, 3'b011);
    chk(rx_data == 8'h01, "R3 double flip bit0", rx_data, 8'h01);
    pulse_read();
    send_char(9'h0FF, 1'b0, 1'b1, 16, 4, 3'b101);
    chk(rx_data == 8'hF7, "R3 double flip bit3", rx_data, 8'hF7);
    pulse_read();
    send_char(9'h000, 1'b0, 1'b1, 16, 8, 3'b110);
    chk(rx_data == 8'h80, "R3 double flip bit7", rx_data, 8'h80);
    pulse_read();

    // R1 R2: spikes of 1..8 low ticks are rejected
    for (int k = 1; k <= 8; k++) begin
      for (int s = 0; s < k; s++) step_tick(1'b0);
      idle_ticks(20);
      chk(rx_done == 1'b0, "R2 spike rejected", rx_done, 0);
    end
    // R1 R2: 9 low ticks makes samples 8 and 9 low, accepted; data then all ones
    for (int s = 0; s < 9; s++) step_tick(1'b0);
    idle_ticks(7 + 16 * 9);
    chk(rx_done == 1'b1 && rx_data == 8'hFF && frame_err == 1'b0, "R2 nine-tick start",
        {rx_done, rx_data}, 9'h1FF);
    pulse_read();
    // R2: start bit with two high votes is dropped
    send_char(9'h1FF, 1'b0, 1'b1, 16, 0, 3'b110);
    chk(rx_done == 1'b0, "R2 start vote high", rx_done, 0);

    // R6: low stop bit
    send_char(9'h05A, 1'b0, 1'b0, 16, -1, 3'b000);
    chk(rx_done == 1'b1 && rx_data == 8'h5A, "R6 delivered", rx_data, 8'h5A);
    chk(frame_err == 1'b1, "R6 framing set", frame_err, 1);
    pulse_read();
    send_char(9'h03C, 1'b0, 1'b1, 16, -1, 3'b000);
    chk(frame_err == 1'b0 && rx_data == 8'h3C, "R6 framing cleared", frame_err, 0);
    pulse_read();

    // R8: overrun
    send_char(9'h011, 1'b0, 1'b1, 16, -1, 3'b000);
    send_char(9'h022, 1'b0, 1'b0, 16, -1, 3'b000);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    chk(rx_data == 8'h11 && frame_err == 1'b0 && rx_done == 1'b1, "R8 old kept",
        {frame_err, rx_data}, 8'h11);
    pulse_read();
    chk(rx_done == 1'b0 && overrun == 1'b1, "R8 overrun after read",
        {rx_done, overrun}, 1);
    send_char(9'h033, 1'b0, 1'b1, 16, -1, 3'b000);
    chk(rx_data == 8'h33 && overrun == 1'b0, "R8 overrun cleared",
        {overrun, rx_data}, 8'h33);
    pulse_read();

    // R9: new start on stop sample 11
    send_char(9'h081, 1'b0, 1'b1, 10, -1, 3'b000);
    chk(rx_done == 1'b1 && rx_data == 8'h81, "R9 first char", rx_data, 8'h81);
    fork
      send_char(9'h07E, 1'b0, 1'b1, 16, -1, 3'b000);
      pulse_read();
    join
    chk(rx_done == 1'b1 && rx_data == 8'h7E && overrun == 1'b0, "R9 back-to-back",
        {overrun, rx_data}, 8'h7E);
    pulse_read();

    // R10: disable abandons a partial character
    send_bit(1'b0, 3'b000);
    send_bit(1'b0, 3'b000);
    send_bit(1'b1, 3'b000);
    rx_en = 1'b0;
    for (int s = 0; s < 5; s++) step_tick(1'b0);
    idle_ticks(2);
    rx_en = 1'b1;
    idle_ticks(20 + 16 * 8);
    chk(rx_done == 1'b0, "R10 partial abandoned", rx_done, 0);
    send_char(9'h0C3, 1'b0, 1'b1, 16, -1, 3'b000);
    chk(rx_done == 1'b1 && rx_data == 8'hC3, "R10 resumes", rx_data, 8'hC3);

    finish_run();
  end
endmodule